// File: doc/BRIEF.md
# Queued DMA Command Engine

This block is a word-oriented DMA engine. Software fills in a source address, a destination address, a source length and a destination length through a small register port. Writing the destination length is the trigger: it takes all four values and places them in a four-deep command queue. The engine works through the queued commands strictly in order, reading the source through a simple request/ready memory master.

The mode comes from a loopback bit that the engine samples at the start of every chunk. When loopback is off, each word it reads goes out on a valid/ready stream toward a downstream consumer. When loopback is on, the engine reads one chunk of up to 256 words into a local buffer and then writes that chunk to the destination.

The block records completion, errors and queue overflow as interrupt status bits that are cleared by writing 1. It combines those bits with a mask to drive one interrupt line, and it reports whether the queue is full or empty.

Top module: `dma_cmd_engine`

## Requirements
- R1: The registers are word-indexed on `reg_addr`: 0 interrupt status, 1 interrupt mask, 2 queue status (read-only), 3 source address, 4 destination address, 5 source length, 6 destination length, 7 mode. After reset these read 0x8802_0000, 0xFFFF_FFFF, 0x4000_0000, and 0 for all the others.
- R2: Lengths are counted in 32-bit words, and only bits 26:0 of each length register are stored and read back. Both addresses have their low two bits cleared when a command is built from them.
- R3: A write to register 6 pushes a command into a 4-entry queue. A command keeps its slot until it retires. Queue status bit 31 means full and bit 30 means empty. A push into a full queue drops the command and sets interrupt status bit 14.
- R4: Queued commands run in the order they were pushed. While the queue is empty, the engine issues no memory request and no stream data.
- R5: With loopback off, the source words are read at ascending word addresses. Each word appears on the stream in the same order, and the destination is never written.
- R6: With loopback on, a chunk is the smallest of 256 words, the remaining source length and the remaining destination length. All reads of a chunk complete before that chunk is written, in ascending order, to the destination.
- R7: Register 7 holds the loopback enable in bit 4. Every other bit of register 7 reads as 0.
- R8: A command retires when both remaining lengths are zero. Retiring sets interrupt status bits 13 and 12. A command with both lengths zero retires without any memory or stream traffic.
- R9: A command that cannot make progress retires with interrupt status bit 15 set and bits 13 and 12 left as they were. This case is a chunk of size zero while one length is still nonzero.
- R10: Writing 1 to interrupt status bits 31, 27, 17, 15, 14, 13 or 12 clears that bit. Writing 0 leaves the bit unchanged.
- R11: `irq` is high exactly when a status bit is set and its mask bit is 0.
- R12: A memory request keeps its address, direction and write data until `mem_ready`. A stream word keeps `st_valid` and `st_data` until `st_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Memory read data |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_ready | input | 1 | Stream sink ready |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the following corner cases:
- A 300-word loopback command that crosses the 256-word chunk boundary. A design that interleaved the reads and writes, or that sized the first chunk wrongly, would show the wrong read count when each write happens.
- Unequal lengths in both modes. A design that waited for both lengths to reach zero would hang and trip the watchdog. A design that reported done on this case would set bits 13 and 12 instead of 15.
- Four commands queued behind a stalled memory, followed by a fifth push. A design that freed a slot at dispatch, or that accepted the fifth command, would show no full flag or would produce extra stream words.
- An unaligned source address and a zero-length command. These expose addresses that are not masked and memory traffic that should not happen.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int DATA_W = 32;
    localparam int LEN_W  = 27;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_ISR      = 3'd0,
        RA_IMASK    = 3'd1,
        RA_QSTAT    = 3'd2,
        RA_SRC_ADDR = 3'd3,
        RA_DST_ADDR = 3'd4,
        RA_SRC_LEN  = 3'd5,
        RA_DST_LEN  = 3'd6,
        RA_MODE     = 3'd7
    } reg_addr_e;

    // interrupt status bit positions
    localparam int ISR_PART_DONE = 12;
    localparam int ISR_DONE      = 13;
    localparam int ISR_QOVF      = 14;
    localparam int ISR_CMD_ERR   = 15;

    localparam logic [DATA_W-1:0] ISR_RESET    = 32'h8802_0000;
    localparam logic [DATA_W-1:0] ISR_W1C_BITS = 32'h8802_F000;

    localparam int QS_FULL   = 31;
    localparam int QS_EMPTY  = 30;
    localparam int LPBK_BIT  = 4;

    typedef struct packed {
        logic [DATA_W-1:0] src_addr;
        logic [DATA_W-1:0] dst_addr;
        logic [LEN_W-1:0]  src_words;
        logic [LEN_W-1:0]  dst_words;
    } dma_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_READ,
        ST_STREAM,
        ST_WRITE
    } mover_state_e;

    function automatic logic [LEN_W-1:0] min_len(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [DATA_W-1:0] word_align(input logic [DATA_W-1:0] a);
        return {a[DATA_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                q_full,
    input  logic                q_empty,
    input  logic                ev_done,
    input  logic                ev_err,
    input  logic                ev_ovf,
    output logic                push,
    output dma_cmd_t            push_cmd,
    output logic                loopback,
    output logic [DATA_W-1:0]   isr_o,
    output logic [DATA_W-1:0]   imask_o,
    output logic                irq
);

    reg_addr_e           ra;
    logic [DATA_W-1:0]   isr_q, imask_q, src_addr_q, dst_addr_q;
    logic [LEN_W-1:0]    src_len_q, dst_len_q;
    logic                lpbk_q;
    logic [DATA_W-1:0]   isr_set, isr_clr;

    assign ra = reg_addr_e'(reg_addr);

    always_comb begin
        isr_set                = '0;
        isr_set[ISR_DONE]      = ev_done;
        isr_set[ISR_PART_DONE] = ev_done;
        isr_set[ISR_CMD_ERR]   = ev_err;
        isr_set[ISR_QOVF]      = ev_ovf;
        isr_clr = (reg_wr && ra == RA_ISR) ? (reg_wdata & ISR_W1C_BITS) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q      <= ISR_RESET;
            imask_q    <= '1;
            src_addr_q <= '0;
            dst_addr_q <= '0;
            src_len_q  <= '0;
            dst_len_q  <= '0;
            lpbk_q     <= 1'b0;
        end else begin
            // hardware events win over a same-cycle clear
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (reg_wr) begin
                case (ra)
                    RA_IMASK:    imask_q    <= reg_wdata;
                    RA_SRC_ADDR: src_addr_q <= reg_wdata;
                    RA_DST_ADDR: dst_addr_q <= reg_wdata;
                    RA_SRC_LEN:  src_len_q  <= reg_wdata[LEN_W-1:0];
                    RA_DST_LEN:  dst_len_q  <= reg_wdata[LEN_W-1:0];
                    RA_MODE:     lpbk_q     <= reg_wdata[LPBK_BIT];
                    default: ;
                endcase
            end
        end
    end

    // command capture: the length being written is taken straight from the bus
    assign push               = reg_wr && (ra == RA_DST_LEN);
    assign push_cmd.src_addr  = word_align(src_addr_q);
    assign push_cmd.dst_addr  = word_align(dst_addr_q);
    assign push_cmd.src_words = src_len_q;
    assign push_cmd.dst_words = reg_wdata[LEN_W-1:0];

    always_comb begin
        reg_rdata = '0;
        case (ra)
            RA_ISR:      reg_rdata = isr_q;
            RA_IMASK:    reg_rdata = imask_q;
            RA_QSTAT: begin
                reg_rdata[QS_FULL]  = q_full;
                reg_rdata[QS_EMPTY] = q_empty;
            end
            RA_SRC_ADDR: reg_rdata = src_addr_q;
            RA_DST_ADDR: reg_rdata = dst_addr_q;
            RA_SRC_LEN:  reg_rdata = DATA_W'(src_len_q);
            RA_DST_LEN:  reg_rdata = DATA_W'(dst_len_q);
            RA_MODE:     reg_rdata[LPBK_BIT] = lpbk_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign loopback = lpbk_q;
    assign isr_o    = isr_q;
    assign imask_o  = imask_q;
    assign irq      = |(isr_q & ~imask_q);

endmodule

// File: rtl/dma_cmd_queue.sv
module dma_cmd_queue
    import dma_eng_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  dma_cmd_t push_cmd,
    input  logic     pop,
    output dma_cmd_t head,
    output logic     full,
    output logic     empty,
    output logic     overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    dma_cmd_t            slot [DEPTH];
    logic [PTR_W-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CNT_W-1:0]    count;
    logic                accept, do_pop;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign accept   = push && !full;
    assign do_pop   = pop && !empty;
    assign overflow = push && full;
    assign head     = slot[rd_ptr];

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wr_nxt = wr_ptr + PTR_W'(1);
            assign rd_nxt = rd_ptr + PTR_W'(1);
        end else begin : g_cmp_wrap
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (accept) slot[wr_ptr] <= push_cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_nxt;
            if (do_pop) rd_ptr <= rd_nxt;
            case ({accept, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_eng_pkg::*;
#(
    parameter int CHUNK_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  dma_cmd_t          cmd,
    input  logic              loopback,
    output logic              pop,
    output logic              ev_done,
    output logic              ev_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              st_valid,
    output logic [DATA_W-1:0] st_data,
    input  logic              st_ready
);

    localparam int IDX_W = $clog2(CHUNK_WORDS);
    localparam int CNT_W = $clog2(CHUNK_WORDS + 1);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(CHUNK_WORDS);

    mover_state_e        state;
    logic [DATA_W-1:0]   cur_src, cur_dst, st_data_q;
    logic [LEN_W-1:0]    rem_src, rem_dst, span;
    logic [CNT_W-1:0]    chunk_len, cnt;
    logic                lb_q, last_word, span_zero;
    logic [IDX_W-1:0]    idx;
    logic [DATA_W-1:0]   chunk_mem [CHUNK_WORDS];

    always_comb begin
        span = min_len(LIMIT, rem_src);
        if (loopback) span = min_len(span, rem_dst);
    end

    assign span_zero = (span == '0);
    assign last_word = (cnt == chunk_len - CNT_W'(1));
    assign idx       = cnt[IDX_W-1:0];

    assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = (state == ST_WRITE) ? cur_dst : cur_src;
    assign mem_wdata = chunk_mem[idx];
    assign st_valid  = (state == ST_STREAM);
    assign st_data   = st_data_q;

    // retirement happens when planning finds no work left
    assign pop     = (state == ST_PLAN) && span_zero;
    assign ev_done = pop && (rem_src == '0) && (rem_dst == '0);
    assign ev_err  = pop && !((rem_src == '0) && (rem_dst == '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_src   <= '0;
            cur_dst   <= '0;
            rem_src   <= '0;
            rem_dst   <= '0;
            chunk_len <= '0;
            cnt       <= '0;
            lb_q      <= 1'b0;
            st_data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cur_src <= cmd.src_addr;
                        cur_dst <= cmd.dst_addr;
                        rem_src <= cmd.src_words;
                        rem_dst <= cmd.dst_words;
                        state   <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    lb_q      <= loopback;
                    chunk_len <= CNT_W'(span);
                    cnt       <= '0;
                    state     <= span_zero ? ST_IDLE : ST_READ;
                end
                ST_READ: begin
                    if (mem_ready) begin
                        cur_src <= cur_src + 32'd4;
                        rem_src <= rem_src - LEN_W'(1);
                        cnt     <= cnt + CNT_W'(1);
                        if (lb_q) begin
                            if (last_word) begin
                                cnt   <= '0;
                                state <= ST_WRITE;
                            end
                        end else begin
                            st_data_q <= mem_rdata;
                            state     <= ST_STREAM;
                        end
                    end
                end
                ST_STREAM: begin
                    if (st_ready) state <= (cnt == chunk_len) ? ST_PLAN : ST_READ;
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        cur_dst <= cur_dst + 32'd4;
                        rem_dst <= rem_dst - LEN_W'(1);
                        cnt     <= cnt + CNT_W'(1);
                        if (last_word) state <= ST_PLAN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state == ST_READ && mem_ready && lb_q) chunk_mem[idx] <= mem_rdata;
    end

endmodule

// File: rtl/dma_cmd_engine.sv
module dma_cmd_engine
    import dma_eng_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4,
    parameter int CHUNK_WORDS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                st_valid,
    output logic [DATA_W-1:0]   st_data,
    input  logic                st_ready,
    output logic                irq
);

    dma_cmd_t          push_cmd, head;
    logic              q_push, q_pop, q_full, q_empty, q_ovf;
    logic              ev_done, ev_err, loopback;
    logic [DATA_W-1:0] isr, imask;

    dma_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .ev_done   (ev_done),
        .ev_err    (ev_err),
        .ev_ovf    (q_ovf),
        .push      (q_push),
        .push_cmd  (push_cmd),
        .loopback  (loopback),
        .isr_o     (isr),
        .imask_o   (imask),
        .irq       (irq)
    );

    dma_cmd_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .push_cmd (push_cmd),
        .pop      (q_pop),
        .head     (head),
        .full     (q_full),
        .empty    (q_empty),
        .overflow (q_ovf)
    );

    dma_mover #(.CHUNK_WORDS(CHUNK_WORDS)) u_mover (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (!q_empty),
        .cmd       (head),
        .loopback  (loopback),
        .pop       (q_pop),
        .ev_done   (ev_done),
        .ev_err    (ev_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .st_valid  (st_valid),
        .st_data   (st_data),
        .st_ready  (st_ready)
    );

endmodule

// File: rtl/dma_cmd_engine_chk.sv
module dma_cmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready,
    input logic        st_valid,
    input logic [31:0] st_data,
    input logic        st_ready,
    input logic        irq,
    input logic        q_push,
    input logic        q_full,
    input logic        q_empty,
    input logic [31:0] isr,
    input logic [31:0] imask,
    input logic        ev_done,
    input logic        ev_err
);

    a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r12_stream_hold: assert property (@(posedge clk) disable iff (rst)
        st_valid && !st_ready |=> st_valid && $stable(st_data));

    a_r3_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        q_push && q_full |=> isr[14]);

    a_r8_done_flags: assert property (@(posedge clk) disable iff (rst)
        ev_done |=> isr[13] && isr[12]);

    a_r9_error_flag: assert property (@(posedge clk) disable iff (rst)
        ev_err |=> isr[15]);

    a_r11_all_masked: assert property (@(posedge clk) disable iff (rst)
        (imask == 32'hFFFF_FFFF) |-> !irq);

    a_r4_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> !mem_req && !st_valid);

endmodule

bind dma_cmd_engine dma_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .st_valid  (st_valid),
    .st_data   (st_data),
    .st_ready  (st_ready),
    .irq       (irq),
    .q_push    (q_push),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .isr       (isr),
    .imask     (imask),
    .ev_done   (ev_done),
    .ev_err    (ev_err)
);

// File: tb/dma_cmd_engine_tb.sv
module dma_cmd_engine_tb;

    localparam logic [2:0] A_ISR = 3'd0, A_IMASK = 3'd1, A_QSTAT = 3'd2, A_SRC = 3'd3,
                           A_DST = 3'd4, A_SLEN = 3'd5, A_DLEN = 3'd6, A_MODE = 3'd7;
    localparam int CHUNK = 256;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        int          rb;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        st_valid;
    logic [31:0] st_data;
    logic        st_ready = 1'b0;
    logic        irq;

    bit          mem_stall = 1'b0;
    int          n_chk = 0, n_bad = 0;
    int          rd_cnt = 0, wr_cnt = 0, st_cnt = 0, exp_rd_total = 0, cyc = 0;
    logic [31:0] exp_rd[$];
    logic [31:0] exp_st[$];
    wr_item_t    exp_wr[$];

    always #4 clk = ~clk;

    dma_cmd_engine u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .st_valid(st_valid), .st_data(st_data), .st_ready(st_ready), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'hA5C3, a[31:16] ^ 16'h1E0F};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic unexpected(input string tag, input logic [31:0] act);
        n_chk++;
        n_bad++;
        $display("FAIL %s: got unexpected transfer %h expected none", tag, act);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // memory and stream responder plus scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_ready = 1'b0;
            if (mem_req && !mem_stall && (cyc % 3 != 1)) begin
                mem_ready = 1'b1;
                if (!mem_we) begin
                    mem_rdata = pat(mem_addr);
                    if (exp_rd.size() == 0) unexpected("R5 read", mem_addr);
                    else check("R4/R5 read address", mem_addr, exp_rd.pop_front());
                    rd_cnt++;
                end else begin
                    wr_cnt++;
                    if (exp_wr.size() == 0) unexpected("R5 write", mem_addr);
                    else begin
                        wr_item_t w;
                        w = exp_wr.pop_front();
                        check("R6 write address", mem_addr, w.addr);
                        check("R6 write data", mem_wdata, w.data);
                        check("R6 reads before write", 32'(rd_cnt), 32'(w.rb));
                    end
                end
            end
            st_ready = (cyc % 4 != 2);
            if (st_valid && st_ready) begin
                st_cnt++;
                if (exp_st.size() == 0) unexpected("R5 stream", st_data);
                else check("R5 stream data", st_data, exp_st.pop_front());
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // driver: queue the expected traffic, then program the command
    task automatic issue(input logic [31:0] src, input logic [31:0] dst, input int sw,
                         input int dw, input bit lb, input bit expect_it);
        logic [31:0] s, d;
        s = {src[31:2], 2'b00};
        d = {dst[31:2], 2'b00};
        if (expect_it) begin
            if (!lb) begin
                for (int i = 0; i < sw; i++) begin
                    exp_rd.push_back(s + 32'(4 * i));
                    exp_st.push_back(pat(s + 32'(4 * i)));
                end
                exp_rd_total += sw;
            end else begin
                int n;
                int base;
                n = (sw < dw) ? sw : dw;
                base = exp_rd_total;
                for (int i = 0; i < n; i++) exp_rd.push_back(s + 32'(4 * i));
                for (int i = 0; i < n; i++) begin
                    int cend;
                    wr_item_t w;
                    cend = ((i / CHUNK) + 1) * CHUNK;
                    if (cend > n) cend = n;
                    w.addr = d + 32'(4 * i);
                    w.data = pat(s + 32'(4 * i));
                    w.rb   = base + cend;
                    exp_wr.push_back(w);
                end
                exp_rd_total += n;
            end
        end
        reg_write(A_SRC, src);
        reg_write(A_DST, dst);
        reg_write(A_SLEN, 32'(sw));
        reg_write(A_DLEN, 32'(dw));
    endtask

    task automatic wait_idle();
        logic [31:0] q;
        q = '0;
        while (!q[30] || exp_rd.size() != 0 || exp_st.size() != 0 || exp_wr.size() != 0)
            reg_read(A_QSTAT, q);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got still running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int traffic;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values, R11 masked at reset
        reg_read(A_ISR, v);   check("R1 isr reset", v, 32'h8802_0000);
        reg_read(A_IMASK, v); check("R1 mask reset", v, 32'hFFFF_FFFF);
        reg_read(A_QSTAT, v); check("R1 queue status reset", v, 32'h4000_0000);
        reg_read(A_MODE, v);  check("R1 mode reset", v, 32'h0);
        check("R11 irq at reset", 32'(irq), 32'h0);

        // R7 only bit 4 of mode is writable
        reg_write(A_MODE, 32'hFFFF_FFFF);
        reg_read(A_MODE, v); check("R7 mode write ones", v, 32'h0000_0010);
        reg_write(A_MODE, 32'h0);
        reg_read(A_MODE, v); check("R7 mode write zero", v, 32'h0);

        // R2 27-bit length
        reg_write(A_SLEN, 32'hF800_0003);
        reg_read(A_SLEN, v); check("R2 length width", v, 32'h0000_0003);

        // R5 stream mode with unaligned source (R2)
        issue(32'h0000_1003, 32'h0, 5, 0, 1'b0, 1'b1);
        wait_idle();
        reg_read(A_ISR, v); check("R8 done after stream", v, 32'h8802_3000);

        // R10 write-one-to-clear
        reg_write(A_ISR, 32'h0);
        reg_read(A_ISR, v); check("R10 zero write no effect", v, 32'h8802_3000);
        reg_write(A_ISR, 32'hFFFF_FFFF);
        reg_read(A_ISR, v); check("R10 clear all", v, 32'h0);

        // R11 masking, R8 zero-length command
        reg_write(A_IMASK, 32'hFFFF_DFFF);
        check("R11 irq idle", 32'(irq), 32'h0);
        traffic = rd_cnt + wr_cnt + st_cnt;
        issue(32'h0000_4000, 32'h0000_5000, 0, 0, 1'b0, 1'b1);
        wait_idle();
        check("R8 zero length no traffic", 32'(rd_cnt + wr_cnt + st_cnt), 32'(traffic));
        check("R11 irq raised by done", 32'(irq), 32'h1);
        reg_write(A_ISR, 32'h0000_2000);
        reg_read(A_ISR, v); check("R10 single clear", v, 32'h0000_1000);
        check("R11 irq after clear", 32'(irq), 32'h0);
        reg_write(A_ISR, 32'hFFFF_FFFF);

        // R6 loopback across a chunk boundary
        reg_write(A_MODE, 32'h10);
        issue(32'h0000_2000, 32'h8000_0002, 300, 300, 1'b1, 1'b1);
        wait_idle();
        reg_read(A_ISR, v); check("R8 loopback done", v, 32'h0000_3000);
        reg_write(A_ISR, 32'hFFFF_FFFF);

        // R6/R9 loopback limited by destination length
        issue(32'h0000_6000, 32'h0000_9000, 10, 4, 1'b1, 1'b1);
        wait_idle();
        reg_read(A_ISR, v); check("R9 loopback stall error", v, 32'h0000_8000);
        reg_write(A_ISR, 32'hFFFF_FFFF);

        // R9 stream mode with leftover destination length
        reg_write(A_MODE, 32'h0);
        issue(32'h0000_7000, 32'h0000_A000, 2, 3, 1'b0, 1'b1);
        wait_idle();
        reg_read(A_ISR, v); check("R9 stream leftover error", v, 32'h0000_8000);
        reg_write(A_ISR, 32'hFFFF_FFFF);

        // R3 overflow and R4 ordering
        mem_stall = 1'b1;
        for (int k = 0; k < 4; k++)
            issue(32'h0001_0000 + 32'(k * 32'h100), 32'h0, 2, 0, 1'b0, 1'b1);
        reg_read(A_QSTAT, v); check("R3 queue full", v, 32'h8000_0000);
        issue(32'h0002_0000, 32'h0, 2, 0, 1'b0, 1'b0);
        reg_read(A_ISR, v); check("R3 overflow flag", v, 32'h0000_4000);
        mem_stall = 1'b0;
        wait_idle();
        reg_read(A_QSTAT, v); check("R3 queue drained", v, 32'h4000_0000);
        reg_read(A_ISR, v); check("R4 queued commands done", v, 32'h0000_7000);

        summary();
        $finish;
    end

endmodule